// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block sits between a synchronous host port and an external asynchronous static RAM of 64K words by 16 bits. The RAM has one shared bidirectional data bus and a separate active-low strobe for each byte lane. Each single-beat host request, read or write, becomes a timed sequence of chip select, write enable, output enable and lane strobes. All timing windows are counted in whole clock cycles. The data bus is handled as three plain signals: a value to drive, a drive enable, and the value sampled from the pins. The pad buffer outside the block merges them.

A transaction moves through four named states. IDLE has every strobe high and waits for a request. Accepting a request latches the address, data, byte mask and direction. SETUP places the address and lowers chip select and the selected lane strobes, while write enable and output enable stay high. A write spends the bus-turnaround count here before the bus is driven. ACTIVE lowers output enable for a read or write enable for a write, and holds it for the access or write-pulse count. The read data is captured on the last ACTIVE edge. RECOVER raises the command strobe and holds the address and chip select for the recovery count. Its last cycle raises the acknowledge, and for a read also the read-valid pulse.

The transitions are as follows. IDLE goes to SETUP on a request with a non-zero mask, and to RECOVER for a single cycle on a request with an all-zero mask. SETUP goes to ACTIVE when its count ends. ACTIVE goes to RECOVER when its count ends. RECOVER goes back to IDLE when its count ends. Output enable stays high for the whole of a write, so the shorter write pulse applies.

Top module: `sram_async_ctrl`

## Requirements
- R1: While reset is held and on the first cycle after it, chip select, write enable, output enable and both lane strobes are high (1), the bus drive enable is 0, and the acknowledge and read-valid outputs are 0.
- R2: A read with a non-zero mask takes ADDR_SETUP_CYC + ACC_CYC + REC_CYC cycles from acceptance to acknowledge. Output enable is low only during the ACC_CYC cycles of ACTIVE. The read-valid pulse coincides with the acknowledge and carries the word stored at the address.
- R3: A write holds write enable low for exactly max(WP_CYC, DSETUP_CYC) consecutive cycles. Output enable stays high for the whole write. Acknowledge follows max(ADDR_SETUP_CYC, TURN_CYC) + max(WP_CYC, DSETUP_CYC) + REC_CYC cycles after acceptance.
- R4: The bus drive enable is never high while output enable is low. It is high during every cycle in which write enable is low, so write data covers the whole pulse and changes only as the pulse ends.
- R5: The memory address does not change while chip select is low. Write enable, output enable and the lane strobes go low only while chip select is low.
- R6: Mask bit 0 maps to lane strobe bit 0, which gates data bits 7:0. Mask bit 1 maps to lane strobe bit 1, which gates bits 15:8. A write changes only the enabled lanes. A read returns zero in the lanes that are not enabled.
- R7: A request with mask 00 drives no strobe and is acknowledged on the cycle after acceptance, with no read-valid pulse. A write of this kind leaves the memory contents unchanged.
- R8: The acknowledge is a single-cycle pulse. Address, data, mask and direction are taken only at acceptance, so changes on the host inputs during a transaction have no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_req | input | 1 | Request, held until acknowledge |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | AW | Word address |
| host_wdata | input | DW | Write data |
| host_be | input | DW/8 | Byte-lane mask, bit 0 = bits 7:0 |
| host_ack | output | 1 | One-cycle completion pulse |
| host_rdata | output | DW | Captured read data |
| host_rvalid | output | 1 | One-cycle read data valid |
| mem_addr | output | AW | Memory address |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_lane_n | output | DW/8 | Byte-lane strobes, active low |
| mem_dq_out | output | DW | Data to drive onto the bus |
| mem_dq_oe | output | 1 | Bus drive enable |
| mem_dq_in | input | DW | Data sampled from the bus |

## Verification
The properties assume that the host keeps its request high until it sees the acknowledge and then drops it before the next edge. They also assume that the cycle counts suit the memory grade at the chosen clock. The bench drives every request on the falling edge and releases it on the falling edge where the acknowledge is observed. Before any traffic it checks each count against the 20 ns period and the 10 ns grade limits. The memory model sends a fixed filler pattern on lanes that are not enabled, so a masking error shows up as a wrong read value.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_SETUP   = 2'd1,
        ST_ACTIVE  = 2'd2,
        ST_RECOVER = 2'd3
    } sram_state_e;

    function automatic int unsigned cyc_max(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction
endpackage

// File: rtl/sram_cyc_timer.sv
module sram_cyc_timer #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          last
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val - CW'(1);
        end else if (cnt != '0) begin
            cnt <= cnt - CW'(1);
        end
    end

    assign last = (cnt == '0);
endmodule

// File: rtl/sram_rd_capture.sv
module sram_rd_capture #(
    parameter int DW = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cap_en,
    input  logic [DW/8-1:0] lane_en,
    input  logic [DW-1:0]   din,
    output logic [DW-1:0]   q
);
    localparam int LANES = DW / 8;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                q[8*i +: 8] <= 8'h00;
            end else if (cap_en) begin
                q[8*i +: 8] <= lane_en[i] ? din[8*i +: 8] : 8'h00;
            end
        end
    end
endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int AW             = 16,
    parameter int DW             = 16,
    parameter int ADDR_SETUP_CYC = 1,
    parameter int ACC_CYC        = 1,
    parameter int WP_CYC         = 1,
    parameter int DSETUP_CYC     = 1,
    parameter int TURN_CYC       = 1,
    parameter int REC_CYC        = 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            host_req,
    input  logic            host_wr,
    input  logic [AW-1:0]   host_addr,
    input  logic [DW-1:0]   host_wdata,
    input  logic [DW/8-1:0] host_be,
    output logic            host_ack,
    output logic [DW-1:0]   host_rdata,
    output logic            host_rvalid,
    output logic [AW-1:0]   mem_addr,
    output logic            mem_cs_n,
    output logic            mem_we_n,
    output logic            mem_oe_n,
    output logic [DW/8-1:0] mem_lane_n,
    output logic [DW-1:0]   mem_dq_out,
    output logic            mem_dq_oe,
    input  logic [DW-1:0]   mem_dq_in
);
    localparam int LANES         = DW / 8;
    localparam int WR_SETUP_CYC  = cyc_max(ADDR_SETUP_CYC, TURN_CYC);
    localparam int WR_PULSE_CYC  = cyc_max(WP_CYC, DSETUP_CYC);
    localparam int MAX_CYC       = cyc_max(cyc_max(WR_SETUP_CYC, WR_PULSE_CYC),
                                           cyc_max(ACC_CYC, REC_CYC));
    localparam int CW            = $clog2(MAX_CYC + 1);

    sram_state_e        state, state_nx;
    logic               cur_wr;
    logic [AW-1:0]      cur_addr;
    logic [DW-1:0]      cur_wdata;
    logic [LANES-1:0]   cur_be;
    logic               tmr_load;
    logic [CW-1:0]      tmr_val;
    logic               tmr_last;
    logic               cap_en;
    logic               accept;

    assign accept = (state == ST_IDLE) && host_req;

    // next-state and timer load
    always_comb begin
        state_nx = state;
        tmr_load = 1'b0;
        tmr_val  = CW'(1);
        unique case (state)
            ST_IDLE: begin
                if (host_req) begin
                    tmr_load = 1'b1;
                    if (host_be == '0) begin
                        state_nx = ST_RECOVER;
                        tmr_val  = CW'(1);
                    end else begin
                        state_nx = ST_SETUP;
                        tmr_val  = host_wr ? CW'(WR_SETUP_CYC) : CW'(ADDR_SETUP_CYC);
                    end
                end
            end
            ST_SETUP: begin
                if (tmr_last) begin
                    state_nx = ST_ACTIVE;
                    tmr_load = 1'b1;
                    tmr_val  = cur_wr ? CW'(WR_PULSE_CYC) : CW'(ACC_CYC);
                end
            end
            ST_ACTIVE: begin
                if (tmr_last) begin
                    state_nx = ST_RECOVER;
                    tmr_load = 1'b1;
                    tmr_val  = CW'(REC_CYC);
                end
            end
            ST_RECOVER: begin
                if (tmr_last) begin
                    state_nx = ST_IDLE;
                end
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // state register and request latch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            cur_wr    <= 1'b0;
            cur_addr  <= '0;
            cur_wdata <= '0;
            cur_be    <= '0;
        end else begin
            state <= state_nx;
            if (accept) begin
                cur_wr    <= host_wr;
                cur_addr  <= host_addr;
                cur_wdata <= host_wdata;
                cur_be    <= host_be;
            end
        end
    end

    sram_cyc_timer #(.CW(CW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .last     (tmr_last)
    );

    assign cap_en = (state == ST_ACTIVE) && !cur_wr && tmr_last;

    sram_rd_capture #(.DW(DW)) u_cap (
        .clk     (clk),
        .rst_n   (rst_n),
        .cap_en  (cap_en),
        .lane_en (cur_be),
        .din     (mem_dq_in),
        .q       (host_rdata)
    );

    // outputs
    always_comb begin
        mem_addr    = cur_addr;
        mem_dq_out  = cur_wdata;
        mem_cs_n    = 1'b1;
        mem_we_n    = 1'b1;
        mem_oe_n    = 1'b1;
        mem_lane_n  = '1;
        mem_dq_oe   = 1'b0;
        host_ack    = 1'b0;
        host_rvalid = 1'b0;
        unique case (state)
            ST_IDLE: begin
            end
            ST_SETUP: begin
                mem_cs_n   = 1'b0;
                mem_lane_n = ~cur_be;
            end
            ST_ACTIVE: begin
                mem_cs_n   = 1'b0;
                mem_lane_n = ~cur_be;
                mem_we_n   = !cur_wr;
                mem_oe_n   = cur_wr;
                mem_dq_oe  = cur_wr;
            end
            ST_RECOVER: begin
                mem_cs_n    = (cur_be == '0);
                mem_lane_n  = ~cur_be;
                host_ack    = tmr_last;
                host_rvalid = tmr_last && !cur_wr && (cur_be != '0);
            end
            default: begin
            end
        endcase
    end
endmodule

// File: rtl/sram_async_ctrl_chk.sv
module sram_async_ctrl_chk #(
    parameter int AW       = 16,
    parameter int DW       = 16,
    parameter int WR_PULSE = 1
) (
    input logic            clk,
    input logic            rst_n,
    input logic            host_ack,
    input logic            host_rvalid,
    input logic [AW-1:0]   mem_addr,
    input logic            mem_cs_n,
    input logic            mem_we_n,
    input logic            mem_oe_n,
    input logic [DW/8-1:0] mem_lane_n,
    input logic            mem_dq_oe
);
    logic [7:0] we_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         we_len <= '0;
        else if (!mem_we_n) we_len <= we_len + 8'd1;
        else                we_len <= '0;
    end

    assert_no_contention_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> mem_oe_n);

    assert_data_covers_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> mem_dq_oe);

    assert_oe_high_in_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> mem_oe_n);

    assert_pulse_length_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (we_len == 8'(WR_PULSE)));

    assert_addr_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_cs_n |=> (mem_cs_n || $stable(mem_addr)));

    assert_strobes_need_cs_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_we_n || !mem_oe_n || (mem_lane_n != '1)) |-> !mem_cs_n);

    assert_ack_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        host_ack |=> !host_ack);

    assert_rvalid_with_ack_R2: assert property (@(posedge clk) disable iff (!rst_n)
        host_rvalid |-> host_ack);
endmodule

bind sram_async_ctrl sram_async_ctrl_chk #(
    .AW(AW), .DW(DW), .WR_PULSE(WR_PULSE_CYC)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .host_ack    (host_ack),
    .host_rvalid (host_rvalid),
    .mem_addr    (mem_addr),
    .mem_cs_n    (mem_cs_n),
    .mem_we_n    (mem_we_n),
    .mem_oe_n    (mem_oe_n),
    .mem_lane_n  (mem_lane_n),
    .mem_dq_oe   (mem_dq_oe)
);

// File: tb/tb_sram_async_ctrl.sv
module tb_sram_async_ctrl;
    localparam int AW = 16, DW = 16;
    localparam int CLK_NS = 20;
    localparam int P_ASU = 1, P_ACC = 2, P_WP = 2, P_DS = 1, P_TURN = 1, P_REC = 1;
    localparam int WR_LAT = ((P_ASU > P_TURN) ? P_ASU : P_TURN)
                          + ((P_WP > P_DS) ? P_WP : P_DS) + P_REC;
    localparam int RD_LAT = P_ASU + P_ACC + P_REC;
    localparam int PULSE  = (P_WP > P_DS) ? P_WP : P_DS;

    logic clk = 1'b0, rst_n = 1'b0;
    logic host_req = 1'b0, host_wr = 1'b0;
    logic [AW-1:0] host_addr = '0;
    logic [DW-1:0] host_wdata = '0;
    logic [1:0] host_be = 2'b00;
    logic host_ack, host_rvalid, mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe;
    logic [DW-1:0] host_rdata, mem_dq_out, mem_dq_in;
    logic [AW-1:0] mem_addr;
    logic [1:0] mem_lane_n;

    int checks = 0, fails = 0;
    logic [15:0] model [256];
    int  we_lo;
    bit  oe_bad, contend, any_strobe, addr_bad;
    logic [AW-1:0] txn_addr;

    always #(CLK_NS/2) clk = ~clk;

    sram_async_ctrl #(.AW(AW), .DW(DW), .ADDR_SETUP_CYC(P_ASU), .ACC_CYC(P_ACC),
        .WP_CYC(P_WP), .DSETUP_CYC(P_DS), .TURN_CYC(P_TURN), .REC_CYC(P_REC)) dut (
        .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_wr(host_wr),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_be(host_be),
        .host_ack(host_ack), .host_rdata(host_rdata), .host_rvalid(host_rvalid),
        .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n),
        .mem_oe_n(mem_oe_n), .mem_lane_n(mem_lane_n), .mem_dq_out(mem_dq_out),
        .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in));

    // memory model: filler 8'hA5 on lanes that are not driven
    always_comb begin
        mem_dq_in = 16'hA5A5;
        if (!mem_cs_n && !mem_oe_n && mem_we_n) begin
            if (!mem_lane_n[0]) mem_dq_in[7:0]  = model[mem_addr[7:0]][7:0];
            if (!mem_lane_n[1]) mem_dq_in[15:8] = model[mem_addr[7:0]][15:8];
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            if (!mem_we_n) we_lo++;
            if (!mem_we_n && !mem_oe_n) oe_bad = 1'b1;
            if (mem_dq_oe && !mem_oe_n) contend = 1'b1;
            if (!mem_cs_n || !mem_we_n || !mem_oe_n || mem_lane_n != 2'b11) any_strobe = 1'b1;
            if (!mem_cs_n && mem_addr != txn_addr) addr_bad = 1'b1;
            if (!mem_cs_n && !mem_we_n && mem_dq_oe) begin
                if (!mem_lane_n[0]) model[mem_addr[7:0]][7:0]  <= mem_dq_out[7:0];
                if (!mem_lane_n[1]) model[mem_addr[7:0]][15:8] <= mem_dq_out[15:8];
            end
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // one transaction; if perturb, host fields change after acceptance
    task automatic txn(input bit wr, input logic [15:0] a, input logic [1:0] be,
                       input logic [15:0] wd, input logic [15:0] exp, input bit perturb);
        int lat = 0;
        @(negedge clk);
        we_lo = 0; oe_bad = 0; contend = 0; any_strobe = 0; addr_bad = 0;
        txn_addr = a;
        host_req = 1'b1; host_wr = wr; host_addr = a; host_be = be; host_wdata = wd;
        do begin
            @(negedge clk);
            lat++;
            if (perturb && lat == 1) begin
                host_addr = a + 16'd1; host_wdata = ~wd; host_be = ~be; host_wr = ~wr;
            end
        end while (!host_ack && lat < 50);
        host_req = 1'b0;
        if (be == 2'b00) begin
            check(lat == 1, "R7 latency", lat, 1);
            check(!host_rvalid, "R7 no rvalid", host_rvalid, 0);
        end else if (wr) begin
            check(lat == WR_LAT, "R3 write latency", lat, WR_LAT);
        end else begin
            check(lat == RD_LAT, "R2 read latency", lat, RD_LAT);
            check(host_rvalid, "R2 rvalid with ack", host_rvalid, 1);
            check(host_rdata == exp, "R2/R6 read data", host_rdata, exp);
        end
        @(negedge clk);
        check(!host_ack, "R8 ack single cycle", host_ack, 0);
        check(!contend, "R4 bus contention", contend, 0);
        check(!addr_bad, "R5/R8 address held", addr_bad, 0);
        if (be == 2'b00)
            check(!any_strobe, "R7 no strobe", any_strobe, 0);
        else if (wr) begin
            check(we_lo == PULSE, "R3 pulse width", we_lo, PULSE);
            check(!oe_bad, "R3 oe high during write", oe_bad, 0);
        end
    endtask

    // wr, addr, be, wdata, expected read
    localparam logic [50:0] VEC [12] = '{
        {1'b1, 16'h0010, 2'b11, 16'h1234, 16'h0000},
        {1'b0, 16'h0010, 2'b11, 16'h0000, 16'h1234},
        {1'b1, 16'h0010, 2'b01, 16'hABCD, 16'h0000},
        {1'b0, 16'h0010, 2'b11, 16'h0000, 16'h12CD},
        {1'b1, 16'h0010, 2'b10, 16'h5566, 16'h0000},
        {1'b0, 16'h0010, 2'b10, 16'h0000, 16'h5500},
        {1'b0, 16'h0010, 2'b01, 16'h0000, 16'h00CD},
        {1'b1, 16'h00FF, 2'b11, 16'hFFFF, 16'h0000},
        {1'b0, 16'h00FF, 2'b11, 16'h0000, 16'hFFFF},
        {1'b1, 16'h0020, 2'b00, 16'h9999, 16'h0000},
        {1'b0, 16'h0020, 2'b11, 16'h0000, 16'h0000},
        {1'b0, 16'h0010, 2'b11, 16'h0000, 16'h55CD}
    };

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks + 1, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) model[i] = 16'h0000;
        // grade limits at 20 ns: pulse 7, access 10, release 5, data overlap 5
        check(P_WP * CLK_NS >= 7, "R3 pulse vs grade", P_WP * CLK_NS, 7);
        check(P_ACC * CLK_NS >= 10, "R2 access vs grade", P_ACC * CLK_NS, 10);
        check(P_TURN * CLK_NS >= 5, "R4 turnaround vs grade", P_TURN * CLK_NS, 5);
        check(PULSE * CLK_NS >= 5, "R4 data overlap vs grade", PULSE * CLK_NS, 5);
        repeat (3) @(negedge clk);
        check({mem_cs_n, mem_we_n, mem_oe_n, mem_lane_n, mem_dq_oe, host_ack, host_rvalid} == 8'b11111000,
              "R1 reset outputs", {mem_cs_n, mem_we_n, mem_oe_n, mem_lane_n, mem_dq_oe, host_ack, host_rvalid}, 8'hF8);
        rst_n = 1'b1;
        @(negedge clk);
        check(mem_cs_n && !mem_dq_oe && !host_ack, "R1 first cycle idle", {mem_cs_n, mem_dq_oe, host_ack}, 3'b100);

        for (int i = 0; i < 12; i++)
            txn(VEC[i][50], VEC[i][49:34], VEC[i][33:32], VEC[i][31:16], VEC[i][15:0], 1'b0);

        // R8: host inputs change mid-transaction
        txn(1'b1, 16'h0030, 2'b11, 16'h7777, 16'h0, 1'b1);
        txn(1'b0, 16'h0030, 2'b11, 16'h0000, 16'h7777, 1'b0);
        txn(1'b0, 16'h0031, 2'b11, 16'h0000, 16'h0000, 1'b0);
        // R6: upper-lane write next to lower-lane data, back-to-back
        txn(1'b1, 16'h0040, 2'b01, 16'h00EE, 16'h0, 1'b0);
        txn(1'b1, 16'h0040, 2'b10, 16'h3300, 16'h0, 1'b0);
        txn(1'b0, 16'h0040, 2'b11, 16'h0000, 16'h33EE, 1'b0);
        // R7: zero-mask read
        txn(1'b0, 16'h0040, 2'b00, 16'h0000, 16'h0000, 1'b0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule